// File: doc/BRIEF.md
# Oversampled Asynchronous Serial Receiver

This block takes one asynchronous serial line and turns it into parallel characters. A clock enable, `os_tick_i`, pulses at sixteen times the bit rate, and the receiver samples the line only on those pulses. When the line falls while the receiver is idle, the receiver does not trust the edge yet. It samples the line again half a bit later, and if the line is high by then, the event counts as noise and is dropped. When the start bit holds, every later bit is sampled once per bit period, close to the middle of the bit.

The character length can be set to 5, 6, 7 or 8 data bits, and an optional parity bit can follow the data. Each character that completes is written to a holding register and raises a ready flag. The receiver also keeps sticky flags for parity errors, framing errors and overrun. A separate detector raises a break indication when the line stays low for longer than two whole frames. The host clears the ready flag with a read strobe and clears the error flags with a clear pulse. All inputs are synchronous to `clk_i`.

Top module: `serial_rx_os16`

## Requirements
- R1: A start is detected on a tick that samples the line low when the previous tick sampled it high. On the eighth tick after that, the line is sampled again. A high sample there drops the event: no character and no flag results.
- R2: After the start bit is confirmed, the line is sampled once every 16 ticks, so each data, parity and stop sample falls on the ninth tick of its bit.
- R3: Data bits arrive least significant first. `char_len_i` selects the count: 0 gives 5 bits, 1 gives 6, 2 gives 7 and 3 gives 8. The character is right-aligned in `data_o`, and the unused upper bits read zero.
- R4: When `par_en_i` is 1, one parity bit follows the data. With `par_even_i`=1, the data and parity bits together must hold an even number of ones. With `par_even_i`=0, they must hold an odd number. A mismatch sets `par_err_o`.
- R5: Only one stop sample is taken. If it is low, `frame_err_o` is set, and the character is still delivered.
- R6: `ready_o` rises only while `rx_en_i` is 1. While `rx_en_i` is 0, the receiver stays idle, and a partly received character is lost.
- R7: If a character completes while `ready_o` is still 1 and no read happens in that cycle, the new character replaces the old one and `overrun_o` is set.
- R8: A `rd_i` pulse clears `ready_o` on the next edge. If a character completes in the same cycle, `ready_o` stays 1 and no overrun is recorded.
- R9: An `err_clr_i` pulse clears the parity, framing and overrun flags. If a character sets an error flag in the same cycle, that flag ends the cycle set.
- R10: After the stop sample, the receiver watches for a start at once, so characters sent back to back with no idle time are all received.
- R11: Let the frame length in bits be start + data + parity + one stop. `break_o` rises after 32 times the frame length of consecutive low ticks. It clears on the edge after any tick that samples the line high.
- R12: After reset, `data_o`, `ready_o`, all error flags and `break_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| os_tick_i | input | 1 | Oversample enable, 16 per bit |
| rx_i | input | 1 | Serial line, idle high |
| rx_en_i | input | 1 | Receive enable |
| char_len_i | input | 2 | Data bit count minus 5 |
| par_en_i | input | 1 | Parity bit present |
| par_even_i | input | 1 | 1 = even parity, 0 = odd parity |
| rd_i | input | 1 | Buffer read strobe |
| err_clr_i | input | 1 | Clear parity, framing and overrun flags |
| data_o | output | 8 | Received character, right-aligned |
| ready_o | output | 1 | Character waiting |
| par_err_o | output | 1 | Sticky parity error |
| frame_err_o | output | 1 | Sticky framing error |
| overrun_o | output | 1 | Sticky overrun |
| break_o | output | 1 | Line held low for two frames |

## Verification
Two host actions can land in the same cycle as a character completing. One is a buffer read, which competes with the new ready flag. The other is an error clear, which competes with a new parity error. The bench places the strobe on the exact tick of the stop sample. For a read, it expects `ready_o` to stay high with no overrun. For a clear, it expects the new parity error to survive. A behavioural model, updated every clock, judges every output on every cycle around these collisions.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;
  typedef enum logic [1:0] {
    RX_IDLE   = 2'd0,
    RX_VERIFY = 2'd1,
    RX_BITS   = 2'd2
  } rx_state_e;
endpackage

// File: rtl/rx_frame_fsm.sv
module rx_frame_fsm
  import serial_rx_pkg::*;
#(
  parameter int OS_RATE  = 16,
  parameter int DATA_W   = 8,
  parameter int MIN_BITS = 5,
  parameter int LEN_W    = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              line_i,
  input  logic              en_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic              par_en_i,
  input  logic              par_even_i,
  output logic              done_o,
  output logic [DATA_W-1:0] data_o,
  output logic              stop_o,
  output logic              perr_o
);
  localparam int HALF  = OS_RATE / 2;
  localparam int CNT_W = $clog2(OS_RATE);
  localparam int IDX_W = $clog2(DATA_W + 3);
  localparam int SEL_W = $clog2(DATA_W);

  rx_state_e         state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [IDX_W-1:0]  idx_q;
  logic [DATA_W-1:0] shr_q;
  logic              px_q;
  logic              prev_q;

  logic [IDX_W-1:0]  nb, last_idx;
  logic              half_end, bit_end;

  always_comb begin
    nb       = IDX_W'(MIN_BITS) + IDX_W'(len_i);
    last_idx = nb + IDX_W'(par_en_i);
    half_end = (cnt_q == CNT_W'(HALF - 1));
    bit_end  = (cnt_q == CNT_W'(OS_RATE - 1));
  end

  // stop sample: last bit slot of the frame
  assign done_o = en_i & tick_i & (state_q == RX_BITS) & bit_end & (idx_q == last_idx);
  assign data_o = shr_q;
  assign stop_o = line_i;
  assign perr_o = par_en_i & (px_q ^ ~par_even_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= RX_IDLE;
      cnt_q   <= '0;
      idx_q   <= '0;
      shr_q   <= '0;
      px_q    <= 1'b0;
      prev_q  <= 1'b1;
    end else begin
      if (tick_i) prev_q <= line_i;
      if (!en_i) begin
        state_q <= RX_IDLE;
      end else if (tick_i) begin
        unique case (state_q)
          RX_IDLE: begin
            if (!line_i && prev_q) begin
              state_q <= RX_VERIFY;
              cnt_q   <= '0;
            end
          end
          RX_VERIFY: begin
            if (half_end) begin
              if (line_i) begin
                state_q <= RX_IDLE;
              end else begin
                state_q <= RX_BITS;
                cnt_q   <= '0;
                idx_q   <= '0;
                shr_q   <= '0;
                px_q    <= 1'b0;
              end
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          RX_BITS: begin
            if (bit_end) begin
              cnt_q <= '0;
              idx_q <= idx_q + 1'b1;
              if (idx_q < nb) begin
                shr_q[idx_q[SEL_W-1:0]] <= line_i;
                px_q <= px_q ^ line_i;
              end else if (idx_q < last_idx) begin
                px_q <= px_q ^ line_i;
              end else begin
                state_q <= RX_IDLE;
              end
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          default: state_q <= RX_IDLE;
        endcase
      end
    end
  end

  a_r1_noise_dropped: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && tick_i && state_q == RX_VERIFY && half_end && line_i) |=> (state_q == RX_IDLE));

  a_r1_edge_starts_check: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && tick_i && state_q == RX_IDLE && !line_i && prev_q) |=> (state_q == RX_VERIFY && cnt_q == '0));

  a_r6_disable_idles: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (state_q == RX_IDLE));

  a_r10_rearm_after_stop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (state_q == RX_IDLE));
endmodule

// File: rtl/rx_holding.sv
module rx_holding #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              done_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              stop_i,
  input  logic              perr_i,
  input  logic              rd_i,
  input  logic              clr_i,
  output logic [DATA_W-1:0] data_o,
  output logic              ready_o,
  output logic              par_err_o,
  output logic              frame_err_o,
  output logic              overrun_o
);
  logic take;
  assign take = done_i & en_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o      <= '0;
      ready_o     <= 1'b0;
      par_err_o   <= 1'b0;
      frame_err_o <= 1'b0;
      overrun_o   <= 1'b0;
    end else begin
      if (take) begin
        data_o  <= data_i;
        ready_o <= 1'b1;
      end else if (rd_i) begin
        ready_o <= 1'b0;
      end
      // set beats clear
      par_err_o   <= (par_err_o   & ~clr_i) | (take & perr_i);
      frame_err_o <= (frame_err_o & ~clr_i) | (take & ~stop_i);
      overrun_o   <= (overrun_o   & ~clr_i) | (take & ready_o & ~rd_i);
    end
  end

  a_r6_ready_needs_enable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ready_o) |-> $past(en_i));

  a_r7_overrun_on_unread: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take && ready_o && !rd_i) |=> (overrun_o && ready_o));

  a_r8_read_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !take) |=> !ready_o);

  a_r8_arrival_beats_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && take) |=> ready_o);

  a_r9_clear_flags: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !take) |=> (!par_err_o && !frame_err_o && !overrun_o));
endmodule

// File: rtl/rx_break_det.sv
module rx_break_det #(
  parameter int OS_RATE  = 16,
  parameter int DATA_W   = 8,
  parameter int MIN_BITS = 5,
  parameter int LEN_W    = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             line_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             par_en_i,
  output logic             break_o
);
  localparam int MAX_BITS = DATA_W + 3;
  localparam int LIM_MAX  = 2 * OS_RATE * MAX_BITS;
  localparam int CW       = $clog2(LIM_MAX + 1);

  logic [CW-1:0] cnt_q, lim;

  // two frames of start + data + parity + one stop
  always_comb
    lim = CW'(2 * OS_RATE) * (CW'(MIN_BITS + 2) + CW'(len_i) + CW'(par_en_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      break_o <= 1'b0;
    end else if (tick_i) begin
      if (line_i) begin
        cnt_q   <= '0;
        break_o <= 1'b0;
      end else begin
        if (cnt_q < lim) cnt_q <= cnt_q + 1'b1;
        if (cnt_q >= lim - 1'b1) break_o <= 1'b1;
      end
    end
  end

  a_r11_high_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && line_i) |=> !break_o);

  a_r11_rise_on_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(break_o) |-> $past(tick_i && !line_i));
endmodule

// File: rtl/serial_rx_os16.sv
module serial_rx_os16 #(
  parameter int OS_RATE  = 16,
  parameter int DATA_W   = 8,
  parameter int MIN_BITS = 5,
  parameter int LEN_W    = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              os_tick_i,
  input  logic              rx_i,
  input  logic              rx_en_i,
  input  logic [LEN_W-1:0]  char_len_i,
  input  logic              par_en_i,
  input  logic              par_even_i,
  input  logic              rd_i,
  input  logic              err_clr_i,
  output logic [DATA_W-1:0] data_o,
  output logic              ready_o,
  output logic              par_err_o,
  output logic              frame_err_o,
  output logic              overrun_o,
  output logic              break_o
);
  logic              done;
  logic [DATA_W-1:0] shr_data;
  logic              stop_bit;
  logic              perr;

  rx_frame_fsm #(
    .OS_RATE (OS_RATE),
    .DATA_W  (DATA_W),
    .MIN_BITS(MIN_BITS),
    .LEN_W   (LEN_W)
  ) u_frame (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (os_tick_i),
    .line_i    (rx_i),
    .en_i      (rx_en_i),
    .len_i     (char_len_i),
    .par_en_i  (par_en_i),
    .par_even_i(par_even_i),
    .done_o    (done),
    .data_o    (shr_data),
    .stop_o    (stop_bit),
    .perr_o    (perr)
  );

  rx_holding #(
    .DATA_W(DATA_W)
  ) u_hold (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (rx_en_i),
    .done_i     (done),
    .data_i     (shr_data),
    .stop_i     (stop_bit),
    .perr_i     (perr),
    .rd_i       (rd_i),
    .clr_i      (err_clr_i),
    .data_o     (data_o),
    .ready_o    (ready_o),
    .par_err_o  (par_err_o),
    .frame_err_o(frame_err_o),
    .overrun_o  (overrun_o)
  );

  rx_break_det #(
    .OS_RATE (OS_RATE),
    .DATA_W  (DATA_W),
    .MIN_BITS(MIN_BITS),
    .LEN_W   (LEN_W)
  ) u_brk (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (os_tick_i),
    .line_i  (rx_i),
    .len_i   (char_len_i),
    .par_en_i(par_en_i),
    .break_o (break_o)
  );
endmodule

// File: tb/serial_rx_os16_tb.sv
`timescale 1ns/1ps
module serial_rx_os16_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       rx = 1'b1;
  logic       en = 1'b1;
  logic [1:0] len = 2'd3;
  logic       pen = 1'b0;
  logic       even = 1'b0;
  logic       rd = 1'b0;
  logic       clr = 1'b0;
  logic [7:0] data_o;
  logic       ready_o, pe_o, fe_o, oe_o, brk_o;

  int checks = 0;
  int failures = 0;
  bit done_run = 0;

  always #2 clk = ~clk;
  always @(posedge clk) tick <= ~tick;

  serial_rx_os16 u_dut (
    .clk_i(clk), .rst_ni(rst_n), .os_tick_i(tick), .rx_i(rx), .rx_en_i(en),
    .char_len_i(len), .par_en_i(pen), .par_even_i(even), .rd_i(rd), .err_clr_i(clr),
    .data_o(data_o), .ready_o(ready_o), .par_err_o(pe_o), .frame_err_o(fe_o),
    .overrun_o(oe_o), .break_o(brk_o)
  );

  // behavioural reference, in ticks
  int m_st, m_prev, m_cnt, m_idx, m_acc, m_px, m_low;
  int m_data, m_ready, m_pe, m_fe, m_oe, m_brk;

  always @(posedge clk or negedge rst_n) begin
    int nb, tot, lim, fin, stopv, perr;
    if (!rst_n) begin
      m_st = 0; m_prev = 1; m_cnt = 0; m_idx = 0; m_acc = 0; m_px = 0; m_low = 0;
      m_data = 0; m_ready = 0; m_pe = 0; m_fe = 0; m_oe = 0; m_brk = 0;
    end else begin
      nb = 5 + int'(len); tot = nb + int'(pen); lim = 32 * (tot + 2);
      fin = 0; stopv = 1;
      if (!en) m_st = 0;
      else if (tick) begin
        if (m_st == 0) begin
          if (rx == 1'b0 && m_prev == 1) begin m_st = 1; m_cnt = 0; end
        end else if (m_st == 1) begin
          m_cnt++;
          if (m_cnt == 8) begin
            if (rx) m_st = 0;
            else begin m_st = 2; m_cnt = 0; m_idx = 0; m_acc = 0; m_px = 0; end
          end
        end else begin
          m_cnt++;
          if (m_cnt == 16) begin
            m_cnt = 0;
            if (m_idx < nb) begin m_acc |= (int'(rx) << m_idx); m_px ^= int'(rx); end
            else if (m_idx < tot) m_px ^= int'(rx);
            else begin fin = 1; stopv = int'(rx); m_st = 0; end
            m_idx++;
          end
        end
      end
      if (tick) m_prev = int'(rx);
      perr = (pen && (m_px != (even ? 0 : 1))) ? 1 : 0;
      m_pe = (clr ? 0 : m_pe) | (fin & perr);
      m_fe = (clr ? 0 : m_fe) | (fin & (stopv == 0 ? 1 : 0));
      m_oe = (clr ? 0 : m_oe) | (fin & m_ready & (rd ? 0 : 1));
      if (fin) begin m_data = m_acc; m_ready = 1; end
      else if (rd) m_ready = 0;
      if (tick) begin
        if (rx) begin m_low = 0; m_brk = 0; end
        else begin
          if (m_low < lim) m_low++;
          if (m_low >= lim) m_brk = 1;
        end
      end
    end
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done_run) begin
      chk("R3 data_o vs model", int'(data_o), m_data);
      chk("R6 ready_o vs model", int'(ready_o), m_ready);
      chk("R4 par_err_o vs model", int'(pe_o), m_pe);
      chk("R5 frame_err_o vs model", int'(fe_o), m_fe);
      chk("R7 overrun_o vs model", int'(oe_o), m_oe);
      chk("R11 break_o vs model", int'(brk_o), m_brk);
    end
  end

  task automatic hold_line(logic v, int n);
    int i = 0;
    rx = v;
    while (i < n) begin
      if (tick) i++;
      @(negedge clk);
    end
  endtask

  // act: 0 none, 1 read on stop sample, 2 clear on stop sample
  task automatic send_char(logic [7:0] d, int act, logic badpar, logic stopv);
    int nb = 5 + int'(len);
    logic p = 1'b0;
    hold_line(1'b0, 16);
    for (int i = 0; i < nb; i++) begin
      hold_line(d[i], 16);
      p ^= d[i];
    end
    if (pen) begin
      if (!even) p = ~p;
      if (badpar) p = ~p;
      hold_line(p, 16);
    end
    if (act == 0) hold_line(stopv, 16);
    else begin
      hold_line(stopv, 8);
      while (!tick) @(negedge clk);
      if (act == 1) rd = 1'b1; else clr = 1'b1;
      @(negedge clk);
      rd = 1'b0; clr = 1'b0;
      hold_line(stopv, 7);
    end
  endtask

  task automatic strobe_rd();
    rd = 1'b1; @(negedge clk); rd = 1'b0; @(negedge clk);
  endtask

  task automatic strobe_clr();
    clr = 1'b1; @(negedge clk); clr = 1'b0; @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R12 reset data", int'(data_o), 0);
    chk("R12 reset flags", int'({ready_o, pe_o, fe_o, oe_o, brk_o}), 0);
    hold_line(1'b1, 20);

    // 8 bits, no parity
    send_char(8'hA5, 0, 1'b0, 1'b1);
    hold_line(1'b1, 4);
    chk("R2 R3 8-bit char ready", int'(ready_o), 1);
    chk("R2 R3 8-bit char value", int'(data_o), 'hA5);
    strobe_rd();
    chk("R8 read clears ready", int'(ready_o), 0);

    // glitch shorter than half a bit
    hold_line(1'b0, 4);
    hold_line(1'b1, 40);
    chk("R1 glitch gives no char", int'(ready_o), 0);
    chk("R1 glitch no framing err", int'(fe_o), 0);

    // 5 bits, even parity, right aligned
    len = 2'd0; pen = 1'b1; even = 1'b1;
    send_char(8'hFF, 0, 1'b0, 1'b1);
    hold_line(1'b1, 4);
    chk("R3 5-bit zero-filled", int'(data_o), 'h1F);
    chk("R4 good even parity", int'(pe_o), 0);
    strobe_rd();

    // 7 bits, odd parity, wrong parity
    len = 2'd2; even = 1'b0;
    send_char(8'h53, 0, 1'b1, 1'b1);
    hold_line(1'b1, 4);
    chk("R4 bad odd parity flagged", int'(pe_o), 1);
    chk("R3 7-bit value", int'(data_o), 'h53);
    strobe_clr();
    chk("R9 clear drops parity err", int'(pe_o), 0);
    strobe_rd();

    // framing: low stop
    len = 2'd3; pen = 1'b0;
    send_char(8'h3C, 0, 1'b0, 1'b0);
    hold_line(1'b1, 20);
    chk("R5 low stop flags framing", int'(fe_o), 1);
    chk("R5 char still delivered", int'(data_o), 'h3C);
    strobe_clr();
    strobe_rd();

    // overrun
    send_char(8'h11, 0, 1'b0, 1'b1);
    hold_line(1'b1, 3);
    send_char(8'h22, 0, 1'b0, 1'b1);
    hold_line(1'b1, 3);
    chk("R7 overrun set", int'(oe_o), 1);
    chk("R7 newer char kept", int'(data_o), 'h22);
    strobe_clr();
    strobe_rd();

    // back to back, read collides with completion
    send_char(8'h81, 0, 1'b0, 1'b1);
    chk("R10 first of pair", int'(data_o), 'h81);
    send_char(8'h7E, 1, 1'b0, 1'b1);
    hold_line(1'b1, 3);
    chk("R10 second of pair", int'(data_o), 'h7E);
    chk("R8 completion beats read", int'(ready_o), 1);
    chk("R8 no overrun on collision", int'(oe_o), 0);
    strobe_rd();

    // clear collides with parity error arrival
    pen = 1'b1; even = 1'b1;
    send_char(8'h0F, 2, 1'b1, 1'b1);
    hold_line(1'b1, 3);
    chk("R9 new parity err survives clear", int'(pe_o), 1);
    strobe_clr();
    strobe_rd();

    // receiver disabled
    pen = 1'b0; en = 1'b0;
    send_char(8'h99, 0, 1'b0, 1'b1);
    hold_line(1'b1, 3);
    chk("R6 disabled gives no ready", int'(ready_o), 0);
    en = 1'b1;
    hold_line(1'b0, 40);
    en = 1'b0;
    @(negedge clk);
    en = 1'b1;
    hold_line(1'b1, 200);
    chk("R6 partial char dropped", int'(ready_o), 0);

    // break: 8 bits, no parity -> 10-bit frame -> 320 ticks
    hold_line(1'b0, 300);
    chk("R11 no break before two frames", int'(brk_o), 0);
    hold_line(1'b0, 30);
    chk("R11 break after two frames", int'(brk_o), 1);
    chk("R5 break char framing err", int'(fe_o), 1);
    hold_line(1'b1, 2);
    chk("R11 break clears on high", int'(brk_o), 0);
    hold_line(1'b1, 10);

    done_run = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule